// File: doc/BRIEF.md
# Serial Configuration Loader for a Dual-Loop Synthesizer

This block is the write-only, three-wire programming port of a synthesizer that has two phase-locked loops: a low-band loop and a high-band loop. An external controller drives a data line, a serial clock and a load strobe. Each rising edge of the serial clock pushes one data bit into a 23-bit shift register. A rising edge on the load strobe copies the shifted word into one of four holding registers. Two address bits at the tail of the word choose the register. The registers are the reference divider of each loop and the feedback divider of each loop.

All three serial inputs are brought into the single system clock domain through a two-flop synchronizer. Edges are detected after synchronization. The word is sent most significant bit first, so the two address bits are the last ones shifted in. A reference word and a feedback word lay their fields out differently. The block decodes every field of the four registers and drives each one out as its own port. After reset the registers hold legal, safe divide ratios.

Top module: `syn_cfg_loader`

## Requirements
- R1: After reset, both reference dividers read 3, both main counts read 3, both swallow counts read 0, both charge-pump selects read 0, both polarity bits read 1, both prescaler selects read 1, and both monitor selects and lock-output selects read 0.
- R2: Each rising edge of the synchronized serial clock shifts the synchronized data bit into bit position 1 (the LSB) of the shift register. Older bits move one position toward position 23, so the first bit sent ends up as the MSB.
- R3: A rising edge of the synchronized load strobe writes exactly one holding register. The other three keep their contents.
- R4: The address is taken with the bit at position 1 as its low bit and the bit at position 2 as its high bit. Address 0 selects the low-band reference register, 1 the high-band reference register, 2 the low-band feedback register and 3 the high-band feedback register.
- R5: In a reference word, positions 3 and 4 are the monitor select (position 3 is its LSB). Positions 5 to 18 are the 14-bit reference ratio, LSB at position 5. Position 19 is the charge-pump current select.
- R6: In a feedback word, position 3 is the lock-output select and position 4 the prescaler select. Position 5 is the phase polarity. Positions 6 to 12 are the 7-bit swallow count (LSB at 6) and positions 13 to 23 the 11-bit main count (LSB at 13).
- R7: Positions 20 to 23 of a reference word have no effect on any output.
- R8: When more than 23 bits are shifted before a load, only the last 23 bits shifted are used.
- R9: The holding registers change only on a load-strobe rising edge. Shifting while the strobe is high, or a falling strobe, leaves every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial bit clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, MSB first |
| ser_le_i | input | 1 | Load strobe, copies on rising edge |
| lo_ref_div_o | output | 14 | Low-band reference ratio |
| lo_mon_sel_o | output | 2 | Low-band monitor select |
| lo_cp_hi_o | output | 1 | Low-band charge-pump high-current select |
| hi_ref_div_o | output | 14 | High-band reference ratio |
| hi_mon_sel_o | output | 2 | High-band monitor select |
| hi_cp_hi_o | output | 1 | High-band charge-pump high-current select |
| lo_fb_main_o | output | 11 | Low-band main count |
| lo_fb_swal_o | output | 7 | Low-band swallow count |
| lo_lock_sel_o | output | 1 | Low-band lock-output select |
| lo_pre_small_o | output | 1 | Low-band prescaler select |
| lo_pd_pol_o | output | 1 | Low-band phase polarity |
| hi_fb_main_o | output | 11 | High-band main count |
| hi_fb_swal_o | output | 7 | High-band swallow count |
| hi_lock_sel_o | output | 1 | High-band lock-output select |
| hi_pre_small_o | output | 1 | High-band prescaler select |
| hi_pd_pol_o | output | 1 | High-band phase polarity |

## Verification
Random words go to random addresses, and each is preceded by a random number of junk bits. A mix-up of field positions, a swapped address bit or a wrong shift direction therefore shows up as a mismatch on some output. After every load the bench compares all four registers, so a write that lands in the wrong register, or that also hits a neighbour, is caught. Directed words cover all-ones and minimum ratios. Two reference words that differ only in their don't-care bits must give identical outputs. A word shifted while the strobe stays high, followed by a falling strobe, must leave every output as it was. That separates a level-triggered or falling-edge load from the required rising-edge load.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int WORD_W  = 23;
  localparam int ADDR_W  = 2;
  localparam int REF_W   = 14;
  localparam int MAIN_W  = 11;
  localparam int SWAL_W  = 7;
  localparam int NLOOP   = 2;
  localparam int NREG    = 2 * NLOOP;
  // bit indices (zero based) inside the shifted word
  localparam int REF_MON_LSB   = ADDR_W;
  localparam int REF_RATIO_LSB = ADDR_W + 2;
  localparam int REF_CP_BIT    = REF_RATIO_LSB + REF_W;
  localparam int FB_LOCK_BIT   = ADDR_W;
  localparam int FB_PRE_BIT    = ADDR_W + 1;
  localparam int FB_POL_BIT    = ADDR_W + 2;
  localparam int FB_SWAL_LSB   = ADDR_W + 3;
  localparam int FB_MAIN_LSB   = FB_SWAL_LSB + SWAL_W;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic [REF_W-1:0] ratio;
    logic [1:0]       mon_sel;
    logic             cp_hi;
  } ref_cfg_t;

  typedef struct packed {
    logic [MAIN_W-1:0] main_cnt;
    logic [SWAL_W-1:0] swal_cnt;
    logic              lock_sel;
    logic              pre_small;
    logic              pd_pol;
  } fb_cfg_t;

  localparam ref_cfg_t REF_RST = '{ratio: REF_W'(3), mon_sel: 2'b00, cp_hi: 1'b0};
  localparam fb_cfg_t  FB_RST  = '{main_cnt: MAIN_W'(3), swal_cnt: '0,
                                   lock_sel: 1'b0, pre_small: 1'b1, pd_pol: 1'b1};

  function automatic logic [ADDR_W-1:0] cfg_addr(input word_t w);
    return w[ADDR_W-1:0];
  endfunction

  function automatic ref_cfg_t decode_ref(input word_t w);
    ref_cfg_t r;
    r.ratio   = w[REF_RATIO_LSB +: REF_W];
    r.mon_sel = w[REF_MON_LSB +: 2];
    r.cp_hi   = w[REF_CP_BIT];
    return r;
  endfunction

  function automatic fb_cfg_t decode_fb(input word_t w);
    fb_cfg_t f;
    f.main_cnt  = w[FB_MAIN_LSB +: MAIN_W];
    f.swal_cnt  = w[FB_SWAL_LSB +: SWAL_W];
    f.lock_sel  = w[FB_LOCK_BIT];
    f.pre_small = w[FB_PRE_BIT];
    f.pd_pol    = w[FB_POL_BIT];
    return f;
  endfunction
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= async_i;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
    end
  end

  assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/cfg_shift_reg.sv
module cfg_shift_reg
  import cfg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  shift_i,
  input  logic  bit_i,
  output word_t word_o
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       word_o <= '0;
    else if (shift_i) word_o <= {word_o[WORD_W-2:0], bit_i};
endmodule

// File: rtl/cfg_hold_bank.sv
module cfg_hold_bank
  import cfg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  word_t           word_i,
  output logic [NREG-1:0] wr_en_o,
  output ref_cfg_t        ref_o [NLOOP],
  output fb_cfg_t         fb_o  [NLOOP]
);
  logic [ADDR_W-1:0] addr;
  assign addr = cfg_addr(word_i);

  for (genvar g = 0; g < NLOOP; g++) begin : g_loop
    assign wr_en_o[g]         = load_i && (addr == ADDR_W'(g));
    assign wr_en_o[NLOOP + g] = load_i && (addr == ADDR_W'(NLOOP + g));

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)          ref_o[g] <= REF_RST;
      else if (wr_en_o[g]) ref_o[g] <= decode_ref(word_i);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                  fb_o[g] <= FB_RST;
      else if (wr_en_o[NLOOP + g]) fb_o[g] <= decode_fb(word_i);
  end
endmodule

// File: rtl/syn_cfg_loader.sv
module syn_cfg_loader
  import cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  input  logic              ser_le_i,
  output logic [REF_W-1:0]  lo_ref_div_o,
  output logic [1:0]        lo_mon_sel_o,
  output logic              lo_cp_hi_o,
  output logic [REF_W-1:0]  hi_ref_div_o,
  output logic [1:0]        hi_mon_sel_o,
  output logic              hi_cp_hi_o,
  output logic [MAIN_W-1:0] lo_fb_main_o,
  output logic [SWAL_W-1:0] lo_fb_swal_o,
  output logic              lo_lock_sel_o,
  output logic              lo_pre_small_o,
  output logic              lo_pd_pol_o,
  output logic [MAIN_W-1:0] hi_fb_main_o,
  output logic [SWAL_W-1:0] hi_fb_swal_o,
  output logic              hi_lock_sel_o,
  output logic              hi_pre_small_o,
  output logic              hi_pd_pol_o
);
  localparam int LO = 0;
  localparam int HI = 1;

  logic [2:0]      sync_q;
  logic            clk_prev, le_prev;
  logic            dat_s, shift_evt, load_evt;
  word_t           sreg;
  logic [NREG-1:0] wr_en;
  ref_cfg_t        ref_q [NLOOP];
  fb_cfg_t         fb_q  [NLOOP];

  cfg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({ser_le_i, ser_clk_i, ser_dat_i}),
    .sync_o  (sync_q)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clk_prev <= 1'b0;
      le_prev  <= 1'b0;
    end else begin
      clk_prev <= sync_q[1];
      le_prev  <= sync_q[2];
    end

  assign dat_s     = sync_q[0];
  assign shift_evt = sync_q[1] & ~clk_prev;
  assign load_evt  = sync_q[2] & ~le_prev;

  cfg_shift_reg u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_i (shift_evt),
    .bit_i   (dat_s),
    .word_o  (sreg)
  );

  cfg_hold_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_evt),
    .word_i  (sreg),
    .wr_en_o (wr_en),
    .ref_o   (ref_q),
    .fb_o    (fb_q)
  );

  assign lo_ref_div_o   = ref_q[LO].ratio;
  assign lo_mon_sel_o   = ref_q[LO].mon_sel;
  assign lo_cp_hi_o     = ref_q[LO].cp_hi;
  assign hi_ref_div_o   = ref_q[HI].ratio;
  assign hi_mon_sel_o   = ref_q[HI].mon_sel;
  assign hi_cp_hi_o     = ref_q[HI].cp_hi;
  assign lo_fb_main_o   = fb_q[LO].main_cnt;
  assign lo_fb_swal_o   = fb_q[LO].swal_cnt;
  assign lo_lock_sel_o  = fb_q[LO].lock_sel;
  assign lo_pre_small_o = fb_q[LO].pre_small;
  assign lo_pd_pol_o    = fb_q[LO].pd_pol;
  assign hi_fb_main_o   = fb_q[HI].main_cnt;
  assign hi_fb_swal_o   = fb_q[HI].swal_cnt;
  assign hi_lock_sel_o  = fb_q[HI].lock_sel;
  assign hi_pre_small_o = fb_q[HI].pre_small;
  assign hi_pd_pol_o    = fb_q[HI].pd_pol;
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        shift_evt,
  input logic        load_evt,
  input logic        dat_s,
  input logic [22:0] sreg,
  input logic [3:0]  wr_en,
  input logic [13:0] lo_ref_div_o,
  input logic        lo_cp_hi_o,
  input logic [10:0] hi_fb_main_o,
  input logic [6:0]  hi_fb_swal_o,
  input logic        lo_pd_pol_o
);
  p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (lo_ref_div_o == 14'd3) && (hi_fb_main_o == 11'd3) && lo_pd_pol_o);

  p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> (sreg[0] == $past(dat_s)) && (sreg[22:1] == $past(sreg[21:0])));

  p_one_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> $countones(wr_en) == 1);

  p_decode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));

  p_ref_layout_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && sreg[1:0] == 2'b00) |=>
      (lo_ref_div_o == $past(sreg[17:4])) && (lo_cp_hi_o == $past(sreg[18])));

  p_fb_layout_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && sreg[1:0] == 2'b11) |=>
      (hi_fb_main_o == $past(sreg[22:12])) && (hi_fb_swal_o == $past(sreg[11:5])));

  p_load_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(lo_ref_div_o) && $stable(hi_fb_main_o) && $stable(lo_pd_pol_o));
endmodule

bind syn_cfg_loader cfg_loader_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .shift_evt    (shift_evt),
  .load_evt     (load_evt),
  .dat_s        (dat_s),
  .sreg         (sreg),
  .wr_en        (wr_en),
  .lo_ref_div_o (lo_ref_div_o),
  .lo_cp_hi_o   (lo_cp_hi_o),
  .hi_fb_main_o (hi_fb_main_o),
  .hi_fb_swal_o (hi_fb_swal_o),
  .lo_pd_pol_o  (lo_pd_pol_o)
);

// File: tb/tb_syn_cfg_loader.sv
`timescale 1ns/1ps
module tb_syn_cfg_loader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk_i = 1'b0, ser_dat_i = 1'b0, ser_le_i = 1'b0;
  logic [13:0] lo_ref_div_o, hi_ref_div_o;
  logic [1:0]  lo_mon_sel_o, hi_mon_sel_o;
  logic        lo_cp_hi_o, hi_cp_hi_o;
  logic [10:0] lo_fb_main_o, hi_fb_main_o;
  logic [6:0]  lo_fb_swal_o, hi_fb_swal_o;
  logic        lo_lock_sel_o, lo_pre_small_o, lo_pd_pol_o;
  logic        hi_lock_sel_o, hi_pre_small_o, hi_pd_pol_o;

  always #4 clk = ~clk;

  syn_cfg_loader dut (.*);

  int tests = 0, fails = 0;
  logic [22:0] shadow = '0;
  logic [13:0] e_ref [2];
  logic [1:0]  e_mon [2];
  logic        e_cp  [2];
  logic [10:0] e_main [2];
  logic [6:0]  e_swal [2];
  logic        e_lock [2], e_pre [2], e_pol [2];

  // take n bits starting at 1-based position pos
  function automatic int unsigned fld(input logic [22:0] w, input int pos, input int n);
    int unsigned v = 0;
    for (int i = 0; i < n; i++) if (w[pos - 1 + i]) v = v | (32'd1 << i);
    return v;
  endfunction

  task automatic model_load(input logic [22:0] w);
    int a = (w[1] ? 2 : 0) + (w[0] ? 1 : 0);
    int lp = a % 2;
    if (a < 2) begin
      e_mon[lp] = 2'(fld(w, 3, 2));
      e_ref[lp] = 14'(fld(w, 5, 14));
      e_cp[lp]  = w[18];
    end else begin
      e_lock[lp] = w[2];
      e_pre[lp]  = w[3];
      e_pol[lp]  = w[4];
      e_swal[lp] = 7'(fld(w, 6, 7));
      e_main[lp] = 11'(fld(w, 13, 11));
    end
  endtask

  task automatic check_all(input string tag);
    logic [75:0] act, exp;
    act = {lo_ref_div_o, lo_mon_sel_o, lo_cp_hi_o, hi_ref_div_o, hi_mon_sel_o, hi_cp_hi_o,
           lo_fb_main_o, lo_fb_swal_o, lo_lock_sel_o, lo_pre_small_o, lo_pd_pol_o,
           hi_fb_main_o, hi_fb_swal_o, hi_lock_sel_o, hi_pre_small_o, hi_pd_pol_o};
    exp = {e_ref[0], e_mon[0], e_cp[0], e_ref[1], e_mon[1], e_cp[1],
           e_main[0], e_swal[0], e_lock[0], e_pre[0], e_pol[0],
           e_main[1], e_swal[1], e_lock[1], e_pre[1], e_pol[1]};
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    ser_dat_i = b;
    wait_clk(3);
    ser_clk_i = 1'b1;
    wait_clk(3);
    ser_clk_i = 1'b0;
    shadow = {shadow[21:0], b};
  endtask

  task automatic send_word(input logic [22:0] w);
    for (int i = 22; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic pulse_le;
    ser_le_i = 1'b1;
    wait_clk(5);
    model_load(shadow);
    ser_le_i = 1'b0;
    wait_clk(5);
  endtask

  logic done = 1'b0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [22:0] w;
    void'($urandom(32'd20240611));
    for (int k = 0; k < 2; k++) begin
      e_ref[k] = 14'd3; e_mon[k] = 2'd0; e_cp[k] = 1'b0;
      e_main[k] = 11'd3; e_swal[k] = 7'd0; e_lock[k] = 1'b0; e_pre[k] = 1'b1; e_pol[k] = 1'b1;
    end
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(4);
    check_all("R1 reset defaults");

    // directed: all-ones ratios to each address (R4, R5, R6)
    for (int a = 0; a < 4; a++) begin
      w = {21'h1FFFFF, a[0] ? 1'b1 : 1'b0, a[1] ? 1'b1 : 1'b0};
      w[1:0] = 2'(a);
      send_word(w);
      pulse_le;
      check_all("R4 R5 R6 all-ones word per address");
    end

    // directed: minimum legal values, low-band reference then feedback (R5, R6)
    send_word({4'h0, 1'b0, 14'd3, 2'b10, 2'b00});
    pulse_le;
    check_all("R5 low-band reference minimum");
    send_word({11'd3, 7'd0, 1'b0, 1'b0, 1'b1, 2'b10});
    pulse_le;
    check_all("R6 low-band feedback minimum");

    // R7: don't-care bits in a reference word
    send_word({4'hF, 1'b1, 14'h1234, 2'b01, 2'b01});
    pulse_le;
    check_all("R7 high-band ref with dummies set");
    send_word({4'h0, 1'b1, 14'h1234, 2'b01, 2'b01});
    pulse_le;
    check_all("R7 high-band ref with dummies clear");

    // R8: overlong word, leading junk discarded
    for (int j = 0; j < 9; j++) send_bit(1'b1);
    send_word({11'd700, 7'd45, 1'b1, 1'b0, 1'b0, 2'b11});
    pulse_le;
    check_all("R8 overlong word to high-band feedback");

    // R9: shifting with strobe high, then falling strobe, no change
    ser_le_i = 1'b1;
    wait_clk(5);
    send_word({11'd99, 7'd9, 3'b111, 2'b10});
    check_all("R9 shift while strobe high");
    ser_le_i = 1'b0;
    wait_clk(6);
    check_all("R9 falling strobe no load");
    pulse_le;
    check_all("R3 R9 rising strobe loads current word");

    // constrained random: random junk prefix, random address
    for (int it = 0; it < 30; it++) begin
      int pre = int'($urandom_range(0, 5));
      for (int j = 0; j < pre; j++) send_bit(1'($urandom));
      w = 23'($urandom);
      send_word(w);
      pulse_le;
      check_all("R2 R3 R4 R8 random word");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule